// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation buffer after a miss. It takes a 32-bit virtual address and the physical page number of the first-level table, which comes from a root register in the processor. It then reads the page table from physical memory. The table is never translated, so every read goes straight to a simple word-read port. The address splits into a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit page offset. Each table entry is one 32-bit word, so an entry sits at its table base plus four times its index.

The walker makes one walk at a time. First it reads the first-level entry, which names the physical page of the second-level table. Then it reads the second-level leaf entry. If both entries are present, it sends the leaf entry and the virtual page number to the refill side as a one-cycle pulse. If either entry marks a page that does not exist, or a page held in backing storage, it stops the walk and instead pulses a page-fault indication for the faulting address.

Entry layout: bit 0 valid, bit 1 resident, bits 4:2 access permissions, bit 5 dirty, bits 11:6 spare, bits 31:12 physical page number.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high and in the first cycle after it is released, busy, mem_req_valid, refill_valid and fault_valid are low and miss_ready is high.
- R2: The first memory request of a walk reads address {root_ppn, vaddr[31:22], 2'b00}, using the root_ppn and miss_vaddr sampled when the miss is accepted.
- R3: When the first-level entry has both bit 0 and bit 1 set, the second request reads {entry[31:12], vaddr[21:12], 2'b00}.
- R4: When the first-level entry lacks bit 0 or bit 1, the walk ends with fault_valid, fault_level = 0 and fault_vaddr equal to the accepted address, and no second-level read is issued.
- R5: When the leaf entry lacks bit 0 or bit 1, the walk ends with fault_valid, fault_level = 1 and fault_vaddr equal to the accepted address, and there is no refill.
- R6: When both entries are present, refill_valid is raised with refill_vpn = vaddr[31:12] and refill_pte equal to the leaf word as read, permission and dirty bits unchanged.
- R7: Each walk ends with exactly one of refill_valid or fault_valid, high for exactly one cycle, and the walker is idle in the next cycle.
- R8: A miss is accepted only when miss_ready is high (idle). busy is high from the cycle after acceptance through the result pulse. A miss_valid raised while busy starts no walk.
- R9: A memory request stays asserted with a stable address until mem_req_ready is seen. Any delay of ready and of the response is tolerated.
- R10: Changes to root_ppn and miss_vaddr during a walk do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, can take a miss |
| miss_vaddr | input | 32 | Virtual address that missed |
| root_ppn | input | 20 | Physical page of the first-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read |
| refill_valid | output | 1 | One-cycle refill pulse |
| refill_vpn | output | 20 | Virtual page number of the refill |
| refill_pte | output | 32 | Leaf entry to load |
| fault_valid | output | 1 | One-cycle page-fault pulse |
| fault_vaddr | output | 32 | Address of the faulting access |
| fault_level | output | 1 | 0: first-level entry missing, 1: leaf missing |

## Verification
The assertions assume the memory side returns exactly one response for each accepted request, never before that request was accepted and never more than one outstanding. They also assume mem_rsp_valid is never raised spontaneously while the walker is idle or still requesting. The bench memory model follows these rules. It drops ready while a read is outstanding, answers each accepted read once after a random delay of zero to four cycles, and raises ready at random otherwise. Miss requests are held only until acceptance or until the result pulse, so any extra request made while busy is seen only where the rules say it must be ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    parameter int VA_W   = 32;
    parameter int PA_W   = 32;
    parameter int OFF_W  = 12;
    parameter int IDX_W  = 10;
    parameter int PTE_W  = 32;
    parameter int ENT_B  = 2;
    parameter int PG_W   = PA_W - OFF_W;
    parameter int VPN_W  = VA_W - OFF_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [PG_W-1:0] ppn;
        logic [5:0]      spare;
        logic            dirty;
        logic [2:0]      perm;
        logic            resident;
        logic            valid;
    } pte_t;

    function automatic logic pte_present(pte_t e);
        return e.valid & e.resident;
    endfunction

    function automatic logic [PA_W-1:0] entry_addr(logic [PG_W-1:0] base_pg,
                                                   logic [IDX_W-1:0] idx);
        return {base_pg, idx, {ENT_B{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic             second_level,
    input  logic [PG_W-1:0]  root_pg,
    input  logic [PG_W-1:0]  table_pg,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  addr
);
    localparam int HI_LSB = VPN_W - IDX_W;

    always_comb begin
        if (second_level)
            addr = entry_addr(table_pg, vpn[IDX_W-1:0]);
        else
            addr = entry_addr(root_pg, vpn[VPN_W-1:HI_LSB]);
    end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] word,
    output logic             present,
    output logic [PG_W-1:0]  next_pg,
    output logic [PTE_W-1:0] leaf
);
    pte_t e;

    always_comb begin
        e       = pte_t'(word);
        present = pte_present(e);
        next_pg = e.ppn;
        leaf    = e;
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_valid,
    input  logic [VA_W-1:0]  miss_vaddr,
    input  logic [PG_W-1:0]  root_ppn,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic             present,
    input  logic [PG_W-1:0]  next_pg,
    input  logic [PTE_W-1:0] leaf,
    output logic             idle,
    output logic             req_valid,
    output logic             second_level,
    output logic             done,
    output logic             fault,
    output logic [VA_W-1:0]  va_q,
    output logic [PG_W-1:0]  root_q,
    output logic [PG_W-1:0]  table_q,
    output logic [PTE_W-1:0] pte_q,
    output logic             level_q
);
    walk_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            root_q  <= '0;
            table_q <= '0;
            pte_q   <= '0;
            level_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (miss_valid) begin
                        va_q   <= miss_vaddr;
                        root_q <= root_ppn;
                        state  <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ: begin
                    if (mem_req_ready) state <= ST_L1_WAIT;
                end
                ST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (present) begin
                            table_q <= next_pg;
                            state   <= ST_L2_REQ;
                        end else begin
                            level_q <= 1'b0;
                            state   <= ST_FAULT;
                        end
                    end
                end
                ST_L2_REQ: begin
                    if (mem_req_ready) state <= ST_L2_WAIT;
                end
                ST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (present) begin
                            pte_q <= leaf;
                            state <= ST_DONE;
                        end else begin
                            level_q <= 1'b1;
                            state   <= ST_FAULT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle         = (state == ST_IDLE);
        req_valid    = (state == ST_L1_REQ) || (state == ST_L2_REQ);
        second_level = (state == ST_L2_REQ);
        done         = (state == ST_DONE);
        fault        = (state == ST_FAULT);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_valid,
    output logic             miss_ready,
    input  logic [VA_W-1:0]  miss_vaddr,
    input  logic [PG_W-1:0]  root_ppn,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             refill_valid,
    output logic [VPN_W-1:0] refill_vpn,
    output logic [PTE_W-1:0] refill_pte,
    output logic             fault_valid,
    output logic [VA_W-1:0]  fault_vaddr,
    output logic             fault_level
);
    logic             idle, second_level, present, level_q;
    logic [PG_W-1:0]  next_pg, root_q, table_q;
    logic [PTE_W-1:0] leaf, pte_q;
    logic [VA_W-1:0]  va_q;

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .miss_valid    (miss_valid),
        .miss_vaddr    (miss_vaddr),
        .root_ppn      (root_ppn),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .present       (present),
        .next_pg       (next_pg),
        .leaf          (leaf),
        .idle          (idle),
        .req_valid     (mem_req_valid),
        .second_level  (second_level),
        .done          (refill_valid),
        .fault         (fault_valid),
        .va_q          (va_q),
        .root_q        (root_q),
        .table_q       (table_q),
        .pte_q         (pte_q),
        .level_q       (level_q)
    );

    ptw_addr_gen u_addr (
        .second_level (second_level),
        .root_pg      (root_q),
        .table_pg     (table_q),
        .vpn          (va_q[VA_W-1:OFF_W]),
        .addr         (mem_req_addr)
    );

    ptw_pte_eval u_eval (
        .word    (mem_rsp_data),
        .present (present),
        .next_pg (next_pg),
        .leaf    (leaf)
    );

    always_comb begin
        miss_ready  = idle;
        busy        = !idle;
        refill_vpn  = va_q[VA_W-1:OFF_W];
        refill_pte  = pte_q;
        fault_vaddr = va_q;
        fault_level = level_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        miss_valid,
    input logic        miss_ready,
    input logic [9:0]  l1_idx,
    input logic        busy,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        refill_valid,
    input logic        fault_valid
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !busy && !mem_req_valid && !refill_valid && !fault_valid);

    a_r2_first_index: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> mem_req_valid && mem_req_addr[11:2] == $past(l1_idx));

    a_r7_refill_pulse: assert property (@(posedge clk) disable iff (rst)
        refill_valid |=> !refill_valid && !busy);

    a_r7_fault_pulse: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> !fault_valid && !busy);

    a_r7_one_result: assert property (@(posedge clk) disable iff (rst)
        !(refill_valid && fault_valid));

    a_r8_busy_on_result: assert property (@(posedge clk) disable iff (rst)
        (refill_valid || fault_valid) |-> busy && !mem_req_valid);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind ptw_walker ptw_walker_chk u_walker_chk (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .l1_idx        (miss_vaddr[31:22]),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .refill_valid  (refill_valid),
    .fault_valid   (fault_valid)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [31:0] miss_vaddr = '0;
    logic [19:0] root_ppn = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        refill_valid;
    logic [19:0] refill_vpn;
    logic [31:0] refill_pte;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic        fault_level;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] req_log [4];
    int          nreq = 0;

    always #4 clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vaddr(miss_vaddr), .root_ppn(root_ppn), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .refill_valid(refill_valid),
        .refill_vpn(refill_vpn), .refill_pte(refill_pte), .fault_valid(fault_valid),
        .fault_vaddr(fault_vaddr), .fault_level(fault_level)
    );

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: one read outstanding, random ready and latency (R9)
    initial begin
        bit          pending = 1'b0;
        int          lat = 0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pending) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(paddr);
                    pending       = 1'b0;
                end else begin
                    lat--;
                end
            end
            mem_req_ready = !pending && !mem_rsp_valid && (($urandom % 4) != 0);
            if (mem_req_valid && mem_req_ready && !rst) begin
                pending = 1'b1;
                paddr   = mem_req_addr;
                lat     = $urandom % 5;
                if (nreq < 4) req_log[nreq] = mem_req_addr;
                nreq++;
            end
        end
    end

    task automatic run_walk(logic [19:0] root, logic [31:0] va,
                            logic [31:0] l1e, logic [31:0] l2e, bit disturb);
        logic [31:0] l1a, l2a, e1, e2;
        bit ok1, ok2;
        int cyc = 0;
        mem.delete();
        l1a = {root, va[31:22], 2'b00};
        mem[l1a] = l1e;
        mem[{l1e[31:12], va[21:12], 2'b00}] = l2e;
        e1  = rd(l1a);
        ok1 = e1[0] & e1[1];
        l2a = {e1[31:12], va[21:12], 2'b00};
        e2  = rd(l2a);
        ok2 = ok1 & e2[0] & e2[1];
        nreq = 0;

        @(negedge clk);
        chk("R8", "miss_ready idle", {31'd0, miss_ready}, 32'd1);
        miss_valid = 1'b1;
        miss_vaddr = va;
        root_ppn   = root;
        @(negedge clk);
        chk("R8", "busy after accept", {31'd0, busy}, 32'd1);
        miss_valid = disturb;
        if (disturb) begin
            miss_vaddr = ~va;   // R10: late changes must not matter
            root_ppn   = ~root;
        end
        do begin
            @(negedge clk);
            cyc++;
        end while (!(refill_valid || fault_valid) && cyc < 300);
        miss_valid = 1'b0;

        chk("R7", "refill", {31'd0, refill_valid}, {31'd0, ok2});
        chk("R7", "fault", {31'd0, fault_valid}, {31'd0, !ok2});
        chk("R2", "first read addr", req_log[0], l1a);
        if (ok2) begin
            chk("R6", "refill vpn", {12'd0, refill_vpn}, {12'd0, va[31:12]});
            chk("R6", "refill pte", refill_pte, e2);
        end else begin
            chk(ok1 ? "R5" : "R4", "fault vaddr", fault_vaddr, va);
            chk(ok1 ? "R5" : "R4", "fault level", {31'd0, fault_level}, {31'd0, ok1});
        end
        if (ok1) chk("R3", "second read addr", req_log[1], l2a);
        chk(ok1 ? "R3" : "R4", "read count", nreq, ok1 ? 2 : 1);
        @(negedge clk);
        chk("R7", "pulse end and idle", {29'd0, refill_valid, fault_valid, busy}, 32'd0);
        chk("R8", "no walk from busy request", nreq, ok1 ? 2 : 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2026));
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs", {27'd0, busy, mem_req_valid, refill_valid, fault_valid, miss_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "after release", {27'd0, busy, mem_req_valid, refill_valid, fault_valid, miss_ready}, 32'd1);

        // directed corner cases
        run_walk(20'h00000, 32'h0000_0000, 32'h0001_2003, 32'hABCD_E03F, 1'b0); // R6 all attribute bits
        run_walk(20'hFFFFF, 32'hFFFF_FFFF, 32'hFFFF_F003, 32'h1234_5003, 1'b1); // R10 extreme indices
        run_walk(20'h12345, 32'h8040_1000, 32'h0000_5002, 32'h0, 1'b0);        // R4 not valid
        run_walk(20'h12345, 32'h8040_1000, 32'h0000_5001, 32'h0, 1'b1);        // R4 not resident
        run_walk(20'h00ABC, 32'h0030_2ABC, 32'h0007_7003, 32'h9999_9001, 1'b0); // R5 leaf not resident
        run_walk(20'h00ABC, 32'h0030_2ABC, 32'h0007_7003, 32'h9999_9002, 1'b1); // R5 leaf not valid

        for (int i = 0; i < 60; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (($urandom % 4) != 0) a[1:0] = 2'b11;
            if (($urandom % 4) != 0) b[1:0] = 2'b11;
            run_walk(20'($urandom), $urandom, a, b, 1'($urandom));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule